// File: doc/BRIEF.md
# Compare Timer with Register Bus

This block is a free-running 32-bit up-counter with a single compare channel, reached by software through a flat 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Three clock-enable pulse inputs stand in for the possible count clocks: a bus-rate tick, a peripheral tick and an oscillator tick. A control field picks one of them. The picked pulse then passes through a general prescaler before it advances the counter. The oscillator pulse can also be divided first by a small dedicated prescaler of its own.

When the counter steps onto the compare value, a sticky match flag is raised. The flag drives the interrupt line when its enable bit is set. Software clears the flag by writing a one to it. A match never reloads or stops the counter, so the counter can also be read as a monotonic time base. Each enabled pulse on the selected input counts once, and there is no stall or back-pressure: a pulse that arrives while the timer is halted is dropped, not held.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: Control bit 0 (offset 0x00) enables counting. While it is clear the counter value at offset 0x24 holds.
- R3: Control bits [8:6] pick the count pulse: code 1 selects the bus tick, code 2 the peripheral tick and code 5 the oscillator tick. Pulses on inputs that are not selected are ignored, and any other code stops counting.
- R4: While the wait input is high, the counter advances only if control bit 3 is set.
- R5: Prescaler bits [11:0] (offset 0x04) divide the selected pulse by field+1. Any write to that register restarts both dividers from zero.
- R6: When control bit 10 is set, the oscillator pulse is first divided by prescaler bits [15:12] plus one. The general divide then applies in series after it.
- R7: Status bit 0 (offset 0x08) sets in the cycle the counter steps onto the compare value and stays set. Writing 1 to it clears it and writing 0 leaves it unchanged.
- R8: The interrupt output equals status bit 0 AND enable bit 0 (offset 0x0C). Writing 0 to the enable masks the interrupt without clearing the status flag.
- R9: The counter is 32 bits, counts by one and is never reloaded by a match. Writes to offset 0x24 are ignored, and control bit 9 is stored and read back.
- R10: The compare register (offset 0x10) reads back all 32 bits. A compare value the counter has already passed raises no flag until the counter comes round to it again.
- R11: If a match and a write-one-to-clear of status bit 0 fall in the same cycle, the flag ends set.
- R12: Control reads back only bits 0, 3, 6-10; prescaler only bits [15:0]; enable only bit 0. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_bus | input | 1 | Bus-rate count pulse |
| tick_per | input | 1 | Peripheral count pulse |
| tick_osc | input | 1 | Oscillator count pulse |
| wait_mode | input | 1 | Low-power wait request |
| irq | output | 1 | Match interrupt |

## Verification
The assertions check several things on every cycle. The counter never moves while disabled or stalled by wait, and only ever steps by one. The flag rises only on the compare value and stays set until a clear. A simultaneous set and clear leaves it set, and a masking write drops the interrupt at once. Only the bench's scenarios can show the rest: the source mapping, the exact divide ratios of the two prescalers in series, that writes to the counter and to unused bits have no effect, and that a compare value already passed raises nothing.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_PRE  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_IER  = 8'h0C;
  localparam logic [7:0] OFS_CMP  = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h24;

  // Count source codes held in the control register.
  localparam logic [2:0] SRC_BUS = 3'd1;
  localparam logic [2:0] SRC_PER = 3'd2;
  localparam logic [2:0] SRC_OSC = 3'd5;

  // Bit positions inside the control word.
  localparam int CB_EN    = 0;
  localparam int CB_WAIT  = 3;
  localparam int CB_SRC   = 6;
  localparam int CB_FREE  = 9;
  localparam int CB_OSCEN = 10;

  // Oscillator divide field starts here in the prescaler word.
  localparam int OSC_LSB = 12;

  typedef struct packed {
    logic       osc_pre_en;
    logic       free_run;
    logic [2:0] src;
    logic       wait_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/cmpt_div.sv
module cmpt_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q >= lim);
  assign tick_o = adv && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (adv)     cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R5: a divider output pulse is always followed by a restarted phase
  AST_DIV_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !restart) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/cmpt_tick_path.sv
module cmpt_tick_path
  import cmpt_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int OSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [PRE_W-1:0] gen_div,
  input  logic [OSC_W-1:0] osc_div,
  input  logic             div_restart,
  input  logic             tick_bus,
  input  logic             tick_per,
  input  logic             tick_osc,
  input  logic             wait_mode,
  output logic             step_o
);
  logic             run;
  logic             osc_out;
  logic             sel_tick;
  logic [OSC_W-1:0] osc_lim;

  assign run     = ctrl.en && (!wait_mode || ctrl.wait_en);
  assign osc_lim = ctrl.osc_pre_en ? osc_div : '0;

  cmpt_div #(.W(OSC_W)) u_osc_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (div_restart),
    .adv     (tick_osc && run),
    .lim     (osc_lim),
    .tick_o  (osc_out)
  );

  always_comb begin
    unique case (ctrl.src)
      SRC_BUS: sel_tick = tick_bus;
      SRC_PER: sel_tick = tick_per;
      SRC_OSC: sel_tick = osc_out;
      default: sel_tick = 1'b0;
    endcase
  end

  cmpt_div #(.W(PRE_W)) u_gen_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (div_restart),
    .adv     (sel_tick && run),
    .lim     (gen_div),
    .tick_o  (step_o)
  );

  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> ctrl.en); // R2
endmodule

// File: rtl/cmpt_core.sv
module cmpt_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          clr_i,
  output logic [DW-1:0] cnt_o,
  output logic          stat_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_nxt;
  logic          stat_q;
  logic          hit;

  assign cnt_nxt = cnt_q + 1'b1;
  assign hit     = step_i && (cnt_nxt == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (step_i) cnt_q <= cnt_nxt;
      stat_q <= hit || (stat_q && !clr_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign stat_o = stat_q;

  AST_CNT_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q); // R7
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> (cnt_q == $past(cmp_i))); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_i) |=> stat_q); // R11
endmodule

// File: rtl/cmpt_regs.sv
module cmpt_regs
  import cmpt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int PRE_W = 12,
  parameter int OSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    cnt_i,
  input  logic             stat_i,
  output ctrl_t            ctrl_o,
  output logic [PRE_W-1:0] gen_div_o,
  output logic [OSC_W-1:0] osc_div_o,
  output logic             ier_o,
  output logic [DW-1:0]    cmp_o,
  output logic             stat_clr_o,
  output logic             div_restart_o,
  output logic [DW-1:0]    bus_rdata
);
  ctrl_t            ctrl_q;
  logic [PRE_W-1:0] gen_q;
  logic [OSC_W-1:0] osc_q;
  logic             ier_q;
  logic [DW-1:0]    cmp_q;
  logic             sel_ctrl, sel_pre, sel_stat, sel_ier, sel_cmp, sel_cnt;

  assign sel_ctrl = (bus_addr == AW'(OFS_CTRL));
  assign sel_pre  = (bus_addr == AW'(OFS_PRE));
  assign sel_stat = (bus_addr == AW'(OFS_STAT));
  assign sel_ier  = (bus_addr == AW'(OFS_IER));
  assign sel_cmp  = (bus_addr == AW'(OFS_CMP));
  assign sel_cnt  = (bus_addr == AW'(OFS_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gen_q  <= '0;
      osc_q  <= '0;
      ier_q  <= 1'b0;
      cmp_q  <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        ctrl_q.en         <= bus_wdata[CB_EN];
        ctrl_q.wait_en    <= bus_wdata[CB_WAIT];
        ctrl_q.src        <= bus_wdata[CB_SRC +: 3];
        ctrl_q.free_run   <= bus_wdata[CB_FREE];
        ctrl_q.osc_pre_en <= bus_wdata[CB_OSCEN];
      end
      if (sel_pre) begin
        gen_q <= bus_wdata[PRE_W-1:0];
        osc_q <= bus_wdata[OSC_LSB +: OSC_W];
      end
      if (sel_ier) ier_q <= bus_wdata[0];
      if (sel_cmp) cmp_q <= bus_wdata;
    end
  end

  assign stat_clr_o    = bus_wr && sel_stat && bus_wdata[0];
  assign div_restart_o = bus_wr && sel_pre;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CB_EN]      = ctrl_q.en;
      bus_rdata[CB_WAIT]    = ctrl_q.wait_en;
      bus_rdata[CB_SRC +: 3] = ctrl_q.src;
      bus_rdata[CB_FREE]    = ctrl_q.free_run;
      bus_rdata[CB_OSCEN]   = ctrl_q.osc_pre_en;
    end
    if (sel_pre) begin
      bus_rdata[PRE_W-1:0]        = gen_q;
      bus_rdata[OSC_LSB +: OSC_W] = osc_q;
    end
    if (sel_stat) bus_rdata[0] = stat_i;
    if (sel_ier)  bus_rdata[0] = ier_q;
    if (sel_cmp)  bus_rdata    = cmp_q;
    if (sel_cnt)  bus_rdata    = cnt_i;
  end

  assign ctrl_o    = ctrl_q;
  assign gen_div_o = gen_q;
  assign osc_div_o = osc_q;
  assign ier_o     = ier_q;
  assign cmp_o     = cmp_q;

  AST_CMP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_cmp) |=> (cmp_q == $past(bus_wdata))); // R10
  AST_CTRL_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl) |=> (ctrl_q.en == $past(bus_wdata[CB_EN]))); // R2
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmpt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int PRE_W = 12,
  parameter int OSC_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_bus,
  input  logic          tick_per,
  input  logic          tick_osc,
  input  logic          wait_mode,
  output logic          irq
);
  localparam int DW = DATA_W;

  ctrl_t            ctrl;
  logic [PRE_W-1:0] gen_div;
  logic [OSC_W-1:0] osc_div;
  logic             ier;
  logic [DW-1:0]    cmp_val;
  logic [DW-1:0]    cnt;
  logic             stat;
  logic             stat_clr;
  logic             div_restart;
  logic             step;

  cmpt_regs #(.AW(AW), .DW(DW), .PRE_W(PRE_W), .OSC_W(OSC_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .cnt_i         (cnt),
    .stat_i        (stat),
    .ctrl_o        (ctrl),
    .gen_div_o     (gen_div),
    .osc_div_o     (osc_div),
    .ier_o         (ier),
    .cmp_o         (cmp_val),
    .stat_clr_o    (stat_clr),
    .div_restart_o (div_restart),
    .bus_rdata     (bus_rdata)
  );

  cmpt_tick_path #(.PRE_W(PRE_W), .OSC_W(OSC_W)) u_ticks (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .gen_div     (gen_div),
    .osc_div     (osc_div),
    .div_restart (div_restart),
    .tick_bus    (tick_bus),
    .tick_per    (tick_per),
    .tick_osc    (tick_osc),
    .wait_mode   (wait_mode),
    .step_o      (step)
  );

  cmpt_core #(.DW(DW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step),
    .cmp_i  (cmp_val),
    .clr_i  (stat_clr),
    .cnt_o  (cnt),
    .stat_o (stat)
  );

  assign irq = stat && ier;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> $stable(cnt)); // R2
  AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && !ctrl.wait_en) |=> $stable(cnt)); // R4
  AST_MASK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_IER) && !bus_wdata[0]) |=> !irq); // R8
endmodule

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_bus = 1'b0, tick_per = 1'b0, tick_osc = 1'b0;
  logic        wait_mode = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
    .tick_per(tick_per), .tick_osc(tick_osc), .wait_mode(wait_mode), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_run = 0;
  int    n_fail = 0;
  logic  chk_req = 1'b0;
  bit    done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                         A_IER = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

  // Monitor: pops one expected item per request, compares away from the edge.
  always @(negedge clk) begin
    if (chk_req && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : bus_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    bus_addr = a;
    q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  // which: bit0 bus, bit1 peripheral, bit2 oscillator; one pulse per cycle
  task automatic ticks(input int which, input int n);
    tick_bus = which[0]; tick_per = which[1]; tick_osc = which[2];
    repeat (n) @(posedge clk);
    #1;
    tick_bus = 1'b0; tick_per = 1'b0; tick_osc = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    expect_reg(A_CTRL, 32'h0, "R1 ctrl");
    expect_reg(A_PRE,  32'h0, "R1 pre");
    expect_reg(A_STAT, 32'h0, "R1 stat");
    expect_reg(A_IER,  32'h0, "R1 ier");
    expect_reg(A_CMP,  32'h0, "R1 cmp");
    expect_reg(A_CNT,  32'h0, "R1 cnt");
    expect_irq(1'b0, "R1 irq");

    // R2 disabled: source selected but no enable
    wr(A_CTRL, 32'h40);
    ticks(1, 5);
    expect_reg(A_CNT, 32'd0, "R2 hold while disabled");
    expect_reg(A_CTRL, 32'h40, "R2 ctrl readback");

    // R3 bus source
    wr(A_CTRL, 32'h41);
    ticks(1, 10);
    expect_reg(A_CNT, 32'd10, "R3 bus tick counts");
    ticks(6, 5);
    expect_reg(A_CNT, 32'd10, "R3 unselected ignored");
    // R3 peripheral source
    wr(A_CTRL, 32'h81);
    ticks(2, 7);
    ticks(1, 3);
    expect_reg(A_CNT, 32'd17, "R3 peripheral tick");
    // R3 oscillator source, no oscillator divide
    wr(A_CTRL, 32'h141);
    ticks(4, 4);
    expect_reg(A_CNT, 32'd21, "R3 oscillator tick");

    // R6 oscillator divide by 8
    wr(A_CTRL, 32'h541);
    wr(A_PRE, 32'h7000);
    expect_reg(A_PRE, 32'h7000, "R6 pre readback");
    ticks(4, 16);
    expect_reg(A_CNT, 32'd23, "R6 osc divide by 8");
    // R6 in series with general divide by 3 -> 24
    wr(A_PRE, 32'h7002);
    ticks(4, 48);
    expect_reg(A_CNT, 32'd25, "R6 series divide");

    // R5 general divide by 4 on bus tick
    wr(A_CTRL, 32'h41);
    wr(A_PRE, 32'h3);
    ticks(1, 8);
    expect_reg(A_CNT, 32'd27, "R5 general divide");
    wr(A_PRE, 32'h0);

    // R4 wait mode
    wait_mode = 1'b1;
    ticks(1, 5);
    expect_reg(A_CNT, 32'd27, "R4 wait stalls");
    wr(A_CTRL, 32'h49);
    ticks(1, 5);
    expect_reg(A_CNT, 32'd32, "R4 wait enable keeps running");
    wait_mode = 1'b0;

    // R7/R8 compare match and interrupt
    wr(A_CMP, 32'd40);
    wr(A_IER, 32'h1);
    ticks(1, 7);
    expect_reg(A_STAT, 32'h0, "R7 no flag before match");
    expect_irq(1'b0, "R8 irq low before match");
    ticks(1, 1);
    expect_reg(A_CNT, 32'd40, "R7 count at match");
    expect_reg(A_STAT, 32'h1, "R7 flag on match");
    expect_irq(1'b1, "R8 irq on match");
    ticks(1, 3);
    expect_reg(A_CNT, 32'd43, "R9 counts past match");
    expect_reg(A_STAT, 32'h1, "R7 flag sticky");
    wr(A_STAT, 32'h0);
    expect_reg(A_STAT, 32'h1, "R7 write 0 no effect");
    wr(A_IER, 32'h0);
    expect_irq(1'b0, "R8 masked");
    expect_reg(A_STAT, 32'h1, "R8 mask keeps flag");
    wr(A_IER, 32'h1);
    expect_irq(1'b1, "R8 unmasked");
    wr(A_STAT, 32'h1);
    expect_reg(A_STAT, 32'h0, "R7 write 1 clears");
    expect_irq(1'b0, "R8 irq after clear");

    // R10 compare behind the counter
    wr(A_CMP, 32'd10);
    ticks(1, 5);
    expect_reg(A_CNT, 32'd48, "R10 count");
    expect_reg(A_STAT, 32'h0, "R10 passed compare no flag");

    // R11 set beats clear in the same cycle
    wr(A_CMP, 32'd50);
    ticks(1, 1);
    bus_addr = A_STAT; bus_wdata = 32'h1; bus_wr = 1'b1; tick_bus = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; tick_bus = 1'b0;
    expect_reg(A_CNT, 32'd50, "R11 count");
    expect_reg(A_STAT, 32'h1, "R11 set wins");
    wr(A_STAT, 32'h1);

    // R9 counter writes ignored
    wr(A_CNT, 32'h0);
    expect_reg(A_CNT, 32'd50, "R9 counter write ignored");
    // R12 unused bits and unmapped offsets
    wr(A_CTRL, 32'hFFFF_FFFF);
    expect_reg(A_CTRL, 32'h0000_07C9, "R12 ctrl mask");
    ticks(7, 4);
    expect_reg(A_CNT, 32'd50, "R3 invalid source stops");
    wr(A_PRE, 32'hFFFF_FFFF);
    expect_reg(A_PRE, 32'h0000_FFFF, "R12 pre mask");
    wr(A_IER, 32'hFFFF_FFFF);
    expect_reg(A_IER, 32'h1, "R12 ier mask");
    expect_reg(A_CMP, 32'd50, "R10 cmp readback");
    expect_reg(8'h18, 32'h0, "R12 unmapped");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule